// File: doc/BRIEF.md
# Modular Exponentiator Register Front-End

This block is the software-facing side of a modular exponentiation engine. It decodes a 32-bit, word-addressed bus that has separate read and write strobes. Through it, software reads identification and version words, sets operand lengths and a mode word, fires the two engine operations and polls their completion. The arithmetic engine is not part of the block. A start/done handshake pair for each operation stands in for it, and a write port lets the engine fill the result bank.

The low part of the address space holds the registers. The high half holds four operand banks, each `2^ADDR_W` words long. Control bits trigger only on a 0-to-1 transition, so software must clear a bit before it can trigger it again. Each status flag drops when its operation starts and returns when the engine reports completion. A start request made while that operation is still running has no effect.

Top module: `mxp_regfront`

## Requirements
- R1: After reset both status flags (ready, valid) are 1, neither start output is asserted, and the control register reads 0.
- R2: Read data is registered and appears one cycle after `bus_rd`. Word 0 reads 0x6D657870 ("mexp"), word 1 reads 0x66726E74 ("frnt") and word 2 reads 0x312E3030 ("1.00").
- R3: A write to the control register (word 8) in which bit 0 goes from 0 to 1 produces a single-cycle `pre_start` in the cycle after the write. Writing bit 0 as 1 again while it is already 1 produces no pulse.
- R4: Bit 1 of the control register acts the same way for `exp_start`.
- R5: Status bit 0 (ready) drops in the same cycle as `pre_start` and rises after the cycle in which `pre_done` is high.
- R6: Status bit 1 (valid) drops in the same cycle as `exp_start` and rises after the cycle in which `exp_done` is high.
- R7: A control rising edge for an operation whose status flag is 0 (running) produces no start pulse and leaves the flag at 0.
- R8: Bits 31:2 of control and status (word 9) read as zero. Control bits 1:0 read back as last written.
- R9: Mode (word 16), modulus bit length (word 17) and exponent bit length (word 18) are read/write and drive `cfg_mode`, `cfg_mod_bits` and `cfg_exp_bits`. Word 19 reads the largest operand width, 32·2^ADDR_W. Word 20 reads the lane count, 2^ARRAY_POW.
- R10: The bank region starts at word 4·2^ADDR_W. It holds the banks in the order modulus, base, exponent, result, each 2^ADDR_W words long. The modulus, base and exponent banks are writable from the bus and read back what was written.
- R11: Bus writes into the result bank are ignored. The engine fills the result bank through `res_wr`/`res_idx`/`res_data`, and the bus reads it back.
- R12: Writes to the read-only words (0, 1, 2, 9, 19, 20) are ignored. Reads of unmapped words (for example word 3 or word 40) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W+3 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pre_start | output | 1 | One-cycle precomputation start |
| pre_done | input | 1 | Precomputation complete |
| exp_start | output | 1 | One-cycle exponentiation start |
| exp_done | input | 1 | Exponentiation complete |
| res_wr | input | 1 | Engine write into result bank |
| res_idx | input | ADDR_W | Result word index |
| res_data | input | 32 | Result word |
| cfg_mode | output | 32 | Mode register value |
| cfg_mod_bits | output | 32 | Modulus bit length |
| cfg_exp_bits | output | 32 | Exponent bit length |

## Verification
The assertions check the handshake on every cycle. Each start pulse lasts one cycle, comes only from a control write with the bit set while the operation is idle, and coincides with its flag falling. A flag rises only after a done. No start is issued while an operation runs, and the upper control and status bits read as zero. The bench scenarios are needed for the rest: the retrigger rule that requires a clear between writes, the exact register and bank decode, data round trips through the banks, protection of the result bank, and ignored writes to constant words.

// File: rtl/mxp_pkg.sv
package mxp_pkg;
  // register word offsets (byte offset / 4)
  localparam int W_ID0   = 0;
  localparam int W_ID1   = 1;
  localparam int W_VER   = 2;
  localparam int W_CTRL  = 8;
  localparam int W_STAT  = 9;
  localparam int W_MODE  = 16;
  localparam int W_MODL  = 17;
  localparam int W_EXPL  = 18;
  localparam int W_BUFB  = 19;
  localparam int W_LANE  = 20;

  localparam int NUM_BANKS = 4;
  localparam int BANK_RES  = 3;

  function automatic logic [31:0] ascii4(input logic [7:0] a, b, c, d);
    return {a, b, c, d};
  endfunction

  function automatic logic [31:0] max_operand_bits(input int aw);
    return 32'(32 << aw);
  endfunction

  function automatic logic [31:0] lane_count(input int pw);
    return 32'(1 << pw);
  endfunction
endpackage

// File: rtl/mxp_trigger.sv
module mxp_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_new,
  input  logic op_done,
  output logic ctl_bit,
  output logic op_start,
  output logic op_flag
);
  logic rise_evt;
  logic fire_evt;

  assign rise_evt = ctl_wr & ctl_new & ~ctl_bit;
  assign fire_evt = rise_evt & op_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_bit  <= 1'b0;
      op_start <= 1'b0;
      op_flag  <= 1'b1;
    end else begin
      if (ctl_wr) ctl_bit <= ctl_new;
      op_start <= fire_evt;
      if (fire_evt)                op_flag <= 1'b0;
      else if (op_done && !op_flag) op_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/mxp_bank.sv
module mxp_bank #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [31:0]      rdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/mxp_regfront.sv
module mxp_regfront
  import mxp_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int ARRAY_POW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W+2:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_rd,
  output logic [31:0]         bus_rdata,
  output logic                pre_start,
  input  logic                pre_done,
  output logic                exp_start,
  input  logic                exp_done,
  input  logic                res_wr,
  input  logic [ADDR_W-1:0]   res_idx,
  input  logic [31:0]         res_data,
  output logic [31:0]         cfg_mode,
  output logic [31:0]         cfg_mod_bits,
  output logic [31:0]         cfg_exp_bits
);
  localparam int AW = ADDR_W + 3;
  localparam logic [AW-1:0] A_ID0  = AW'(W_ID0);
  localparam logic [AW-1:0] A_ID1  = AW'(W_ID1);
  localparam logic [AW-1:0] A_VER  = AW'(W_VER);
  localparam logic [AW-1:0] A_CTRL = AW'(W_CTRL);
  localparam logic [AW-1:0] A_STAT = AW'(W_STAT);
  localparam logic [AW-1:0] A_MODE = AW'(W_MODE);
  localparam logic [AW-1:0] A_MODL = AW'(W_MODL);
  localparam logic [AW-1:0] A_EXPL = AW'(W_EXPL);
  localparam logic [AW-1:0] A_BUFB = AW'(W_BUFB);
  localparam logic [AW-1:0] A_LANE = AW'(W_LANE);

  // address decode
  logic              in_banks;
  logic [1:0]        bank_sel;
  logic [ADDR_W-1:0] bank_idx;
  logic              ctl_wr;
  assign in_banks = bus_addr[AW-1];
  assign bank_sel = bus_addr[ADDR_W+1:ADDR_W];
  assign bank_idx = bus_addr[ADDR_W-1:0];
  assign ctl_wr   = bus_wr && (bus_addr == A_CTRL);

  // control / status
  logic pre_ctl, exp_ctl, st_ready, st_valid;

  mxp_trigger u_pre (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_new(bus_wdata[0]),
    .op_done(pre_done), .ctl_bit(pre_ctl), .op_start(pre_start), .op_flag(st_ready)
  );
  mxp_trigger u_exp (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_new(bus_wdata[1]),
    .op_done(exp_done), .ctl_bit(exp_ctl), .op_start(exp_start), .op_flag(st_valid)
  );

  // configuration words
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode     <= '0;
      cfg_mod_bits <= '0;
      cfg_exp_bits <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MODE) cfg_mode     <= bus_wdata;
      if (bus_addr == A_MODL) cfg_mod_bits <= bus_wdata;
      if (bus_addr == A_EXPL) cfg_exp_bits <= bus_wdata;
    end
  end

  // operand banks
  logic [31:0] bank_rd [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    if (g == BANK_RES) begin : g_res
      mxp_bank #(.IDX_W(ADDR_W)) u_mem (
        .clk(clk), .we(res_wr), .widx(res_idx), .wdata(res_data),
        .ridx(bank_idx), .rdata(bank_rd[g])
      );
    end else begin : g_in
      logic bwe;
      assign bwe = bus_wr && in_banks && (bank_sel == 2'(g));
      mxp_bank #(.IDX_W(ADDR_W)) u_mem (
        .clk(clk), .we(bwe), .widx(bank_idx), .wdata(bus_wdata),
        .ridx(bank_idx), .rdata(bank_rd[g])
      );
    end
  end

  // read mux
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (in_banks) begin
      rd_mux = bank_rd[bank_sel];
    end else begin
      case (bus_addr)
        A_ID0:  rd_mux = ascii4("m", "e", "x", "p");
        A_ID1:  rd_mux = ascii4("f", "r", "n", "t");
        A_VER:  rd_mux = ascii4("1", ".", "0", "0");
        A_CTRL: rd_mux = {30'd0, exp_ctl, pre_ctl};
        A_STAT: rd_mux = {30'd0, st_valid, st_ready};
        A_MODE: rd_mux = cfg_mode;
        A_MODL: rd_mux = cfg_mod_bits;
        A_EXPL: rd_mux = cfg_exp_bits;
        A_BUFB: rd_mux = max_operand_bits(ADDR_W);
        A_LANE: rd_mux = lane_count(ARRAY_POW);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/mxp_regfront_chk.sv
module mxp_regfront_chk
  import mxp_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [1:0]    ctl_bits,
  input logic          bus_rd,
  input logic [31:2]   rd_hi,
  input logic          pre_start,
  input logic          pre_done,
  input logic          exp_start,
  input logic          exp_done,
  input logic          st_ready,
  input logic          st_valid
);
  AST_PRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start |=> !pre_start); // R3
  AST_EXP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exp_start |=> !exp_start); // R4
  AST_PRE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start |-> $past(bus_wr && bus_addr == AW'(W_CTRL) && ctl_bits[0] && st_ready)); // R3
  AST_EXP_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    exp_start |-> $past(bus_wr && bus_addr == AW'(W_CTRL) && ctl_bits[1] && st_valid)); // R4
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start |-> !st_ready); // R5
  AST_READY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ready) |-> $past(pre_done)); // R5
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    exp_start |-> !st_valid); // R6
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_valid) |-> $past(exp_done)); // R6
  AST_BUSY_NO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |=> !pre_start); // R7
  AST_BUSY_NO_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> !exp_start); // R7
  AST_CS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && (bus_addr == AW'(W_CTRL) || bus_addr == AW'(W_STAT))) |-> rd_hi == '0); // R8
endmodule

bind mxp_regfront mxp_regfront_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .ctl_bits(bus_wdata[1:0]), .bus_rd(bus_rd), .rd_hi(bus_rdata[31:2]),
  .pre_start(pre_start), .pre_done(pre_done), .exp_start(exp_start),
  .exp_done(exp_done), .st_ready(st_ready), .st_valid(st_valid)
);

// File: tb/mxp_regfront_tb.sv
module mxp_regfront_tb;
  localparam int AW_P = 5;
  localparam int PW_P = 2;
  localparam int BW   = 1 << AW_P;
  localparam int AW   = AW_P + 3;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0, pre_done = 0, exp_done = 0, res_wr = 0;
  logic [31:0] bus_wdata = '0, res_data = '0;
  logic [AW_P-1:0] res_idx = '0;
  logic [31:0] bus_rdata, cfg_mode, cfg_mod_bits, cfg_exp_bits;
  logic pre_start, exp_start;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mxp_regfront #(.ADDR_W(AW_P), .ARRAY_POW(PW_P)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pre_start(pre_start), .pre_done(pre_done), .exp_start(exp_start),
    .exp_done(exp_done), .res_wr(res_wr), .res_idx(res_idx), .res_data(res_data),
    .cfg_mode(cfg_mode), .cfg_mod_bits(cfg_mod_bits), .cfg_exp_bits(cfg_exp_bits)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); bus_addr = AW'(a); bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic pulse_done(input bit which);
    @(negedge clk); if (which) exp_done = 1; else pre_done = 1;
    @(negedge clk); exp_done = 0; pre_done = 0;
  endtask

  function automatic int bank_base(input int b);
    return 4 * BW + b * BW;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pre_start", 32'(pre_start), 0);
    chk("R1 exp_start", 32'(exp_start), 0);
    rd(9, d); chk("R1 status", d, 32'h3);
    rd(8, d); chk("R1 control", d, 32'h0);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    rd(0, d); chk("R2 id0", d, 32'h6D657870);
    rd(1, d); chk("R2 id1", d, 32'h66726E74);
    rd(2, d); chk("R2 version", d, 32'h312E3030);
  endtask

  task automatic t_pre();
    logic [31:0] d;
    wr(8, 32'h1);
    chk("R3 pulse", 32'(pre_start), 1);
    chk("R5 ready drop", 32'(u_dut.pre_start & 1'b1), 1);
    @(negedge clk); chk("R3 one cycle", 32'(pre_start), 0);
    rd(9, d); chk("R5 ready low", d, 32'h2);
    pulse_done(0);
    rd(9, d); chk("R5 ready back", d, 32'h3);
    wr(8, 32'h1); chk("R3 held high no pulse", 32'(pre_start), 0);
    rd(8, d); chk("R8 ctrl readback", d, 32'h1);
    wr(8, 32'h0); chk("R3 clear no pulse", 32'(pre_start), 0);
    wr(8, 32'h1); chk("R3 retrigger", 32'(pre_start), 1);
    pulse_done(0);
    wr(8, 32'h0);
  endtask

  task automatic t_exp();
    logic [31:0] d;
    wr(8, 32'h2);
    chk("R4 pulse", 32'(exp_start), 1);
    chk("R4 no pre", 32'(pre_start), 0);
    @(negedge clk); chk("R4 one cycle", 32'(exp_start), 0);
    rd(9, d); chk("R6 valid low", d, 32'h1);
    pulse_done(1);
    rd(9, d); chk("R6 valid back", d, 32'h3);
    wr(8, 32'hFFFF_FFFE); chk("R4 held no pulse", 32'(exp_start), 0);
    rd(8, d); chk("R8 ctrl upper zero", d, 32'h2);
    wr(8, 32'h0);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    wr(8, 32'h3);
    chk("R7 both start", {30'd0, exp_start, pre_start}, 32'h3);
    wr(8, 32'h0);
    wr(8, 32'h3);
    chk("R7 ignored while busy", {30'd0, exp_start, pre_start}, 32'h0);
    rd(9, d); chk("R7 flags stay low", d, 32'h0);
    pulse_done(0); pulse_done(1);
    rd(9, d); chk("R7 flags restored", d, 32'h3);
    wr(8, 32'h0);
    wr(9, 32'h0);
    rd(9, d); chk("R12 status write ignored", d, 32'h3);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(16, 32'hA5);
    wr(17, 32'd1024);
    wr(18, 32'd17);
    chk("R9 cfg_mode", cfg_mode, 32'hA5);
    chk("R9 cfg_mod_bits", cfg_mod_bits, 32'd1024);
    chk("R9 cfg_exp_bits", cfg_exp_bits, 32'd17);
    rd(17, d); chk("R9 modlen read", d, 32'd1024);
    rd(19, d); chk("R9 buffer bits", d, 32'(32 * BW));
    rd(20, d); chk("R9 lanes", d, 32'(1 << PW_P));
  endtask

  task automatic t_banks();
    logic [31:0] d;
    for (int b = 0; b < 3; b++) begin
      wr(bank_base(b), 32'h1000 + b);
      wr(bank_base(b) + BW - 1, 32'h2000 + b);
    end
    for (int b = 0; b < 3; b++) begin
      rd(bank_base(b), d); chk("R10 bank first", d, 32'h1000 + b);
      rd(bank_base(b) + BW - 1, d); chk("R10 bank last", d, 32'h2000 + b);
    end
  endtask

  task automatic t_result();
    logic [31:0] d;
    @(negedge clk); res_wr = 1; res_idx = 5'd4; res_data = 32'hCAFE0004;
    @(negedge clk); res_wr = 0;
    rd(bank_base(3) + 4, d); chk("R11 engine write", d, 32'hCAFE0004);
    wr(bank_base(3) + 4, 32'h0BAD0BAD);
    rd(bank_base(3) + 4, d); chk("R11 bus write ignored", d, 32'hCAFE0004);
    rd(bank_base(2), d); chk("R11 exponent untouched", d, 32'h1002);
  endtask

  task automatic t_ro();
    logic [31:0] d;
    wr(0, 32'h0); wr(2, 32'h0); wr(19, 32'h0); wr(20, 32'h0);
    rd(0, d); chk("R12 id0 kept", d, 32'h6D657870);
    rd(2, d); chk("R12 version kept", d, 32'h312E3030);
    rd(19, d); chk("R12 buffer bits kept", d, 32'(32 * BW));
    rd(20, d); chk("R12 lanes kept", d, 32'(1 << PW_P));
    wr(3, 32'h1234); rd(3, d); chk("R12 unmapped 3", d, 32'h0);
    rd(40, d); chk("R12 unmapped 40", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_pre();
    t_exp();
    t_busy();
    t_cfg();
    t_banks();
    t_result();
    t_ro();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule